// File: doc/BRIEF.md
# Multimode Capture/Compare Timer

This block is a general-purpose 16-bit up-counter with an 8-bit prescaler in front of it. The counter can be stepped by the system clock, by the system clock divided by a fixed power of two, or by rising edges on an external pin; the last choice turns it into an event counter. Whatever source is chosen, every (P+1)-th tick from that source advances the counter, where P is the prescale value.

Two functions watch the counter. Capture copies the counter into a holding register when the synchronized input pin shows the selected edge. Compare raises an event when a counter step lands on the reference value; it can restart the count at that point, and it drives the output pin either as a one-cycle low pulse or as a toggle. Each event sets its own sticky flag, which software clears by writing a one. The interrupt line is the OR of each flag gated by its own enable. Software reaches every register through a simple write port and a combinational read port.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the control, reference, capture, counter and status registers read zero, the output pin is high and the interrupt line is low.
- R2: Control bits [1:0] choose the tick source: 0 stops the counter, 1 gives one tick per clock, 2 gives one tick every 16 clocks, and 3 gives one tick per rising edge of the synchronized input pin (event counting).
- R3: Control bits [15:8] hold the prescale value P, and the counter advances once every P+1 source ticks. A write to the counter register (address 3) loads the written value, clears the prescaler and suppresses the tick for that cycle.
- R4: With control bit 4 clear, the counter wraps from 0xFFFF to 0x0000.
- R5: With control bit 4 set, a tick taken while the counter equals the reference (address 1) returns the counter to zero.
- R6: A compare match occurs on the tick that brings the counter to the reference value. It sets status bit 1 (address 4).
- R7: With control bit 5 clear, the output pin goes low for exactly the one cycle after a match and is high otherwise. With bit 5 set, the output pin inverts after each match.
- R8: Control bits [3:2] choose the capture edge (0 none, 1 rising, 2 falling, 3 both). The input passes through two synchronizer flops, and the capture register (address 2) takes the counter value of the cycle in which the synchronized edge is seen, two clocks after the pin changes. A capture also sets status bit 0.
- R9: Writing the status register clears each flag whose bit is written as one. Bits written as zero leave their flags unchanged, and a flag set in the same cycle as its clear stays set.
- R10: The interrupt line is high exactly while (status bit 0 and control bit 6) or (status bit 1 and control bit 7).
- R11: A capture and a compare match that fall in the same cycle are both recorded: both flags are set and the capture value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 control, 1 reference, 3 counter, 4 status) |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address (0 control, 1 reference, 2 capture, 3 counter, 4 status) |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| tmr_in | input | 1 | External capture and event input |
| tmr_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land on the same clock edge. The first is a capture edge and a compare match. The bench provokes it by setting the reference one step past the counter value that is current when a delayed pin edge reaches the synchronizer output. It expects both flags set and the capture register to hold the count that precedes the match. The second is a flag being set while software clears it. The bench times a write-one-to-clear so that it lands on the match edge and expects the compare flag to survive. Both cases are also judged on every cycle by the behavioural model.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

    localparam int CNT_W_DEF = 16;
    localparam int PSC_W     = 8;
    localparam int ADDR_W    = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_REF  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CAP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

    typedef enum logic [1:0] {
        SRC_OFF = 2'd0,
        SRC_SYS = 2'd1,
        SRC_DIV = 2'd2,
        SRC_PIN = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic [PSC_W-1:0] pre;
        logic             cmp_ie;
        logic             cap_ie;
        logic             toggle;
        logic             restart;
        logic [1:0]       edge_sel;
        clk_src_e         src;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.sh = {sync_q.sh[STAGES-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise = sync_q.sh[STAGES-1] & ~sync_q.sh[STAGES];
    assign fall = ~sync_q.sh[STAGES-1] & sync_q.sh[STAGES];

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import capcmp_pkg::*;
#(
    parameter int PW    = 8,
    parameter int DIV_W = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  clk_src_e      src,
    input  logic          pin_rise,
    input  logic [PW-1:0] pre,
    input  logic          clr,
    output logic          inc
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PW-1:0]    psc;
    } tick_t;

    tick_t t_d, t_q;
    logic  src_tick;

    always_comb begin
        unique case (src)
            SRC_SYS: src_tick = 1'b1;
            SRC_DIV: src_tick = &t_q.div;
            SRC_PIN: src_tick = pin_rise;
            default: src_tick = 1'b0;
        endcase
    end

    always_comb begin
        t_d     = t_q;
        inc     = 1'b0;
        t_d.div = t_q.div + DIV_W'(1);
        if (clr) begin
            t_d.psc = '0;
        end else if (src_tick) begin
            if (t_q.psc >= pre) begin
                t_d.psc = '0;
                inc     = 1'b1;
            end else begin
                t_d.psc = t_q.psc + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
    import capcmp_pkg::*;
#(
    parameter int CNT_W       = CNT_W_DEF,
    parameter int DIV_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    input  logic              tmr_in,
    output logic              tmr_out,
    output logic              irq
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] ref_v;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic             cap_flag;
        logic             cmp_flag;
        logic             out;
    } state_t;

    state_t           st_d, st_q;
    logic             rise, fall;
    logic             inc, match, cap_ev, cnt_wr, stat_wr;
    logic [CNT_W-1:0] cnt_nxt;

    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (tmr_in),
        .rise (rise),
        .fall (fall)
    );

    tmr_tick_gen #(.PW(PSC_W), .DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (st_q.ctrl.src),
        .pin_rise(rise),
        .pre     (st_q.ctrl.pre),
        .clr     (cnt_wr),
        .inc     (inc)
    );

    assign cnt_wr  = wr_en && (wr_addr == A_CNT);
    assign stat_wr = wr_en && (wr_addr == A_STAT);

    always_comb begin
        st_d    = st_q;
        cnt_nxt = (st_q.ctrl.restart && (st_q.cnt == st_q.ref_v)) ? '0
                                                                  : st_q.cnt + CNT_W'(1);
        match   = inc && (cnt_nxt == st_q.ref_v);
        cap_ev  = (st_q.ctrl.edge_sel[0] && rise) || (st_q.ctrl.edge_sel[1] && fall);

        if (inc)    st_d.cnt = cnt_nxt;
        if (cap_ev) st_d.cap = st_q.cnt;

        st_d.cap_flag = cap_ev | (st_q.cap_flag & ~(stat_wr & wr_data[0]));
        st_d.cmp_flag = match  | (st_q.cmp_flag & ~(stat_wr & wr_data[1]));
        st_d.out      = st_q.ctrl.toggle ? (st_q.out ^ match) : ~match;

        if (wr_en) begin
            unique case (wr_addr)
                A_CTRL:  st_d.ctrl  = ctrl_t'(wr_data[CTRL_W-1:0]);
                A_REF:   st_d.ref_v = wr_data;
                A_CNT:   st_d.cnt   = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.out <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = CNT_W'(st_q.ctrl);
            A_REF:   rd_data = st_q.ref_v;
            A_CAP:   rd_data = st_q.cap;
            A_CNT:   rd_data = st_q.cnt;
            A_STAT:  rd_data = CNT_W'({st_q.cmp_flag, st_q.cap_flag});
            default: rd_data = '0;
        endcase
    end

    assign tmr_out = st_q.out;
    assign irq     = (st_q.cap_flag & st_q.ctrl.cap_ie) | (st_q.cmp_flag & st_q.ctrl.cmp_ie);

endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             inc,
    input logic             match,
    input logic             cap_ev,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] ref_v,
    input logic [CNT_W-1:0] cap,
    input logic             cap_flag,
    input logic             cmp_flag,
    input logic             restart,
    input logic             toggle,
    input logic             out,
    input logic             irq
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (out && !irq && !cap_flag && !cmp_flag));

    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + CNT_W'(1)) || cnt == '0));

    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && inc && cnt == ref_v) |=> cnt == '0);

    assert_match_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> cmp_flag);

    assert_pulse_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !toggle) |=> !out);

    assert_pulse_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!match && !toggle) |=> out);

    assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && toggle) |=> out != $past(out));

    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_ev |=> (cap == $past(cnt) && cap_flag));

    assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cap_flag || cmp_flag));

endmodule

bind capcmp_timer capcmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (inc),
    .match   (match),
    .cap_ev  (cap_ev),
    .cnt_wr  (cnt_wr),
    .cnt     (st_q.cnt),
    .ref_v   (st_q.ref_v),
    .cap     (st_q.cap),
    .cap_flag(st_q.cap_flag),
    .cmp_flag(st_q.cmp_flag),
    .restart (st_q.ctrl.restart),
    .toggle  (st_q.ctrl.toggle),
    .out     (st_q.out),
    .irq     (irq)
);

// File: tb/capcmp_timer_bench.sv
module capcmp_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [2:0]  rd_addr;
    logic [15:0] rd_data;
    logic        tmr_in;
    logic        tmr_out;
    logic        irq;

    always #4 clk = ~clk;

    capcmp_timer u_capcmp_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tmr_in(tmr_in), .tmr_out(tmr_out), .irq(irq)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model, stepped on every rising edge
    bit m_s1, m_s2, m_s3, m_fc, m_fm, m_out;
    int m_div, m_psc, m_cnt, m_ref, m_ctrl, m_cap;

    always @(posedge clk) begin
        bit rise, fall, tick, inc, match, capev, cw, sw;
        int nxt, pre, src;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_fc = 0; m_fm = 0; m_out = 1;
            m_div = 0; m_psc = 0; m_cnt = 0; m_ref = 0; m_ctrl = 0; m_cap = 0;
        end else begin
            src   = m_ctrl & 3;
            pre   = (m_ctrl >> 8) & 255;
            rise  = m_s2 && !m_s3;
            fall  = !m_s2 && m_s3;
            cw    = wr_en && wr_addr == 3;
            sw    = wr_en && wr_addr == 4;
            tick  = (src == 1) || (src == 2 && m_div == 15) || (src == 3 && rise);
            inc   = 0;
            if (cw) m_psc = 0;
            else if (tick) begin
                if (m_psc >= pre) begin m_psc = 0; inc = 1; end
                else m_psc = m_psc + 1;
            end
            nxt   = (((m_ctrl >> 4) & 1) == 1 && m_cnt == m_ref) ? 0 : (m_cnt + 1) & 16'hFFFF;
            match = inc && nxt == m_ref;
            capev = (((m_ctrl >> 2) & 1) == 1 && rise) || (((m_ctrl >> 3) & 1) == 1 && fall);
            if (capev) m_cap = m_cnt;
            m_fc  = capev || (m_fc && !(sw && wr_data[0]));
            m_fm  = match || (m_fm && !(sw && wr_data[1]));
            m_out = (((m_ctrl >> 5) & 1) == 1) ? (m_out ^ match) : !match;
            if (inc) m_cnt = nxt;
            if (wr_en && wr_addr == 0) m_ctrl = wr_data;
            if (wr_en && wr_addr == 1) m_ref  = wr_data;
            if (cw) m_cnt = wr_data;
            m_div = (m_div + 1) % 16;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = tmr_in;
        end
    end

    always @(negedge clk) begin
        int exp_rd;
        if (rst_n) begin
            case (rd_addr)
                3'd0: exp_rd = m_ctrl;
                3'd1: exp_rd = m_ref;
                3'd2: exp_rd = m_cap;
                3'd3: exp_rd = m_cnt;
                3'd4: exp_rd = m_fm * 2 + m_fc;
                default: exp_rd = 0;
            endcase
            case (rd_addr)
                3'd0: chk("R2 model ctrl", rd_data, exp_rd);
                3'd1: chk("R6 model ref", rd_data, exp_rd);
                3'd2: chk("R8 model cap", rd_data, exp_rd);
                3'd3: chk("R3 model cnt", rd_data, exp_rd);
                default: chk("R9 model status", rd_data, exp_rd);
            endcase
            chk("R7 model out", tmr_out, m_out);
            chk("R10 model irq", irq, (m_fc && m_ctrl[6]) || (m_fm && m_ctrl[7]));
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            summary();
            $finish;
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        rd_addr = 3'(a);
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic rdv(input int a, output int v);
        rd_addr = 3'(a);
        #1;
        v = rd_data;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int a, b, o0;
        rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; tmr_in = 0;
        cyc(3);
        rst_n = 1;
        for (int i = 0; i < 5; i++) rd(i, 0, "R1 reset register");
        chk("R1 reset out", tmr_out, 1);
        chk("R1 reset irq", irq, 0);
        cyc(5);
        rd(3, 0, "R2 stopped source");

        // R2 one tick per clock
        wr(0, 16'h0001);
        rdv(3, a); cyc(10); rdv(3, b);
        chk("R2 system clock steps", b - a, 10);

        // R3 prescale 3 with counter load
        wr(0, 16'h0301); wr(3, 0);
        cyc(40);
        rd(3, 10, "R3 prescale divide");

        // R2 divided clock
        wr(0, 16'h0002); wr(3, 0);
        cyc(64);
        rd(3, 4, "R2 divided source");

        // R2 event counting
        wr(0, 16'h0003); wr(3, 0);
        for (int i = 0; i < 5; i++) begin
            tmr_in = 1; cyc(3); tmr_in = 0; cyc(3);
        end
        cyc(3);
        rd(3, 5, "R2 pin events");

        // R4 wrap
        wr(0, 16'h0001); wr(3, 16'hFFFE);
        cyc(3);
        rd(3, 1, "R4 wrap");
        wr(4, 3);
        rd(4, 0, "R9 flags cleared");

        // R5 restart, R6 match flag, R7 pulse
        wr(1, 5); wr(0, 16'h0011); wr(3, 0);
        cyc(4);
        chk("R7 out high before match", tmr_out, 1);
        cyc(1);
        chk("R7 pulse low", tmr_out, 0);
        rd(3, 5, "R6 counter at reference");
        rd(4, 2, "R6 compare flag");
        cyc(1);
        chk("R7 pulse one cycle", tmr_out, 1);
        rd(3, 0, "R5 restart to zero");
        cyc(2);
        rd(3, 2, "R5 counting after restart");

        // R7 toggle
        wr(0, 16'h0031); wr(3, 0);
        o0 = tmr_out;
        cyc(4);
        chk("R7 toggle hold", tmr_out, o0);
        cyc(1);
        chk("R7 toggle first", tmr_out, !o0);
        cyc(5);
        chk("R7 toggle hold2", tmr_out, !o0);
        cyc(1);
        chk("R7 toggle second", tmr_out, o0);

        // R8 rising capture
        wr(4, 3); wr(0, 16'h0005); wr(3, 0);
        cyc(10);
        tmr_in = 1;
        cyc(4);
        rd(2, 12, "R8 rising capture value");
        rd(4, 3, "R8 capture flag");

        // R8 falling capture
        wr(4, 3); wr(0, 16'h0009); wr(3, 0);
        cyc(20);
        tmr_in = 0;
        cyc(4);
        rd(2, 22, "R8 falling capture value");
        rd(4, 3, "R8 falling flag");
        wr(4, 1);
        tmr_in = 1;
        cyc(4);
        rd(4, 2, "R8 rise ignored in fall mode, R9 selective clear");
        rd(2, 22, "R8 capture unchanged");
        wr(4, 0);
        rd(4, 2, "R9 zero write no effect");

        // R11 capture and match in one cycle
        wr(4, 3); wr(1, 12); wr(0, 16'h000D); wr(3, 0);
        cyc(9);
        tmr_in = 0;
        cyc(2);
        rd(4, 0, "R11 flags before coincidence");
        cyc(1);
        rd(4, 3, "R11 both flags");
        rd(2, 11, "R11 capture value");

        // R10 interrupt gating
        wr(0, 16'h004D);
        chk("R10 capture enable irq", irq, 1);
        wr(4, 1);
        chk("R10 irq drop", irq, 0);
        wr(0, 16'h008D);
        chk("R10 compare enable irq", irq, 1);
        wr(4, 2);
        chk("R10 irq cleared", irq, 0);

        // R9 set wins over clear
        wr(4, 3); wr(1, 6); wr(0, 16'h0011); wr(3, 0);
        cyc(5);
        wr(4, 2);
        rd(4, 2, "R9 set beats clear");
        wr(4, 2);
        rd(4, 0, "R9 later clear");

        cyc(5);
        summary();
        $finish;
    end

endmodule